// File: doc/BRIEF.md
# Split-Capable Event Performance Counter Unit

This block counts hardware events for performance analysis. It holds four physical 32-bit counters. Software can split any of them at run time into two independent 16-bit halves, which gives up to eight logical counters. Each logical counter has its own control word. The control word picks one of 64 event lines, can invert that line, and chooses between counting rising edges and counting every clock in which the conditioned line is high.

Counting runs only when the global enable is set and the freeze control is clear. The current privilege state on `priv_i` must also match the filter mode, unless the filter mode is "all". When an increment brings a counter to its all-ones value, the unit sets a sticky overflow flag for that logical counter. The counter then either wraps to zero or stays at the maximum, as the global stop-at-max bit selects. The flags are cleared when the status register is read. An interrupt is raised while any flag is set whose mask bit is also set.

Software reaches every register through a 32-bit word port with separate read and write strobes. Read data is combinational from the address.

Top module: `pmon_core`

## Requirements
- R1: After reset, every register and counter reads zero and `irq_o` is low.
- R2: The register map is: global control at address 0, status at 1, interrupt mask at 2, physical counter n at 8+n, control word k at 16+k. Writes keep only the implemented bits. Global control keeps 0xC1FC0000, control words keep 0xFFC00000 and the mask keeps 0xFF000000.
- R3: A control word holds the event select in bits 31:26, invert in bit 24, cycle mode in bit 23 and counter enable in bit 22. In cycle mode the counter adds one for every clock in which the selected event, XORed with invert, is high.
- R4: With bit 23 clear, the counter adds one only when the conditioned event goes from low to high between two clocks.
- R5: When physical counter n is not split, it is one 32-bit counter that carries across bit 16. It is driven only by control word n.
- R6: Global control bit (24−n) splits physical counter n. The low half is then logical counter n and the high half is logical counter n+4. Each half uses its own control word, and no carry passes between the halves.
- R7: No counter changes value while global bit 31 is clear, while global bit 20 is set, or while the counter's own enable bit 22 is clear.
- R8: Global bits 19:18 filter on `priv_i` (0 supervisor, 1 hypervisor, 2 user). Counting happens only when `priv_i` equals the field, or when the field is 3.
- R9: When global bit 30 is set, a counter at its all-ones value holds there. When bit 30 is clear, the counter wraps to zero.
- R10: The status register bit (31−k) becomes set when an increment brings logical counter k to all ones. The bit stays set until the status register is read. That read returns the bit and clears it.
- R11: `irq_o` is high exactly while some status bit (31−k) is set together with mask bit (31−k).
- R12: A software write to a counter in the same clock as an increment stores the written value, and the increment is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_i | input | NUM_EV | Event lines |
| priv_i | input | 2 | Current privilege state |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (clears status on the status address) |
| reg_addr_i | input | 5 | Register word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| irq_o | output | 1 | Masked overflow interrupt |

## Verification
The bench builds the unit with its default parameters: four physical counters and 64 event lines. With these values every select code addresses a real line, and every split bit and status bit lies in its fixed position. The bench preloads counters to a few steps below the 16-bit and 32-bit limits. This brings carry, wrap, hold-at-max and flag setting within reach in a handful of clocks. The bench drives the lines that are not selected to the opposite level of the selected one, so a wrong select shows up as a wrong count.

// File: rtl/pmon_pkg.sv
package pmon_pkg;

    localparam int REG_W  = 32;
    localparam int ADDR_W = 5;

    // global control field positions
    localparam int GC_ENABLE    = 31;
    localparam int GC_STOPMAX   = 30;
    localparam int GC_SPLIT_TOP = 24;
    localparam int GC_FREEZE    = 20;
    localparam int GC_MODE_HI   = 19;
    localparam int GC_MODE_LO   = 18;

    // per-counter control word field positions
    localparam int CW_SEL_LO = 26;
    localparam int CW_INV    = 24;
    localparam int CW_CYC    = 23;
    localparam int CW_EN     = 22;

    // status / mask flag for logical counter k sits at ST_TOP - k
    localparam int ST_TOP = 31;

    localparam logic [ADDR_W-1:0] A_GCTL  = 5'd0;
    localparam logic [ADDR_W-1:0] A_STAT  = 5'd1;
    localparam logic [ADDR_W-1:0] A_IMASK = 5'd2;
    localparam logic [ADDR_W-1:0] A_CNT   = 5'd8;
    localparam logic [ADDR_W-1:0] A_CW    = 5'd16;

    localparam logic [REG_W-1:0] GCTL_MASK  = 32'hC1FC_0000;
    localparam logic [REG_W-1:0] CW_MASK    = 32'hFFC0_0000;
    localparam logic [REG_W-1:0] IMASK_MASK = 32'hFF00_0000;

    typedef enum logic [1:0] {
        PRIV_SUP = 2'd0,
        PRIV_HYP = 2'd1,
        PRIV_USR = 2'd2,
        PRIV_ANY = 2'd3
    } priv_filter_e;

endpackage

// File: rtl/pmon_evt_cond.sv
module pmon_evt_cond #(
    parameter int NUM_EV = 64,
    parameter int SEL_W  = $clog2(NUM_EV)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EV-1:0] ev_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic              inv_i,
    input  logic              cyc_i,
    input  logic              gate_i,
    output logic              inc_o
);

    logic lvl;
    logic prev_d, prev_q;

    always_comb begin
        lvl    = ev_i[sel_i] ^ inv_i;
        prev_d = lvl;
        if (cyc_i) begin
            inc_o = gate_i & lvl;
        end else begin
            inc_o = gate_i & lvl & ~prev_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= prev_d;
        end
    end

endmodule

// File: rtl/pmon_phys_ctr.sv
module pmon_phys_ctr #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         split_i,
    input  logic         stop_i,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic         inc_lo_i,
    input  logic         inc_hi_i,
    output logic [W-1:0] val_o,
    output logic         hit_lo_o,
    output logic         hit_hi_o
);

    localparam int HW = W / 2;

    logic [W-1:0] val_d, val_q;

    always_comb begin
        val_d    = val_q;
        hit_lo_o = 1'b0;
        hit_hi_o = 1'b0;
        if (wr_i) begin
            val_d = wdata_i;
        end else if (!split_i) begin
            if (inc_lo_i) begin
                if (&val_q) begin
                    if (!stop_i) val_d = '0;
                end else begin
                    val_d    = val_q + 1'b1;
                    hit_lo_o = &val_d;
                end
            end
        end else begin
            if (inc_lo_i) begin
                if (&val_q[HW-1:0]) begin
                    if (!stop_i) val_d[HW-1:0] = '0;
                end else begin
                    val_d[HW-1:0] = val_q[HW-1:0] + 1'b1;
                    hit_lo_o      = &val_d[HW-1:0];
                end
            end
            if (inc_hi_i) begin
                if (&val_q[W-1:HW]) begin
                    if (!stop_i) val_d[W-1:HW] = '0;
                end else begin
                    val_d[W-1:HW] = val_q[W-1:HW] + 1'b1;
                    hit_hi_o      = &val_d[W-1:HW];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q <= '0;
        end else begin
            val_q <= val_d;
        end
    end

    assign val_o = val_q;

endmodule

// File: rtl/pmon_core.sv
module pmon_core
    import pmon_pkg::*;
#(
    parameter int NUM_PHYS = 4,
    parameter int NUM_EV   = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EV-1:0] ev_i,
    input  logic [1:0]        priv_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [4:0]        reg_addr_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    output logic              irq_o
);

    localparam int NUM_LOG = 2 * NUM_PHYS;
    localparam int SEL_W   = $clog2(NUM_EV);

    typedef struct packed {
        logic [REG_W-1:0]                gctl;
        logic [REG_W-1:0]                imask;
        logic [NUM_LOG-1:0]              stat;
        logic [NUM_LOG-1:0][REG_W-1:0]   cw;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [REG_W-1:0]          gctl_q;
    logic [NUM_LOG-1:0]        stat_q;
    logic [NUM_PHYS*REG_W-1:0] cnt_flat;
    logic [NUM_LOG-1:0]        inc_vec;
    logic [NUM_LOG-1:0]        hit_vec;
    logic [NUM_LOG-1:0]        mask_vec;
    logic [NUM_PHYS-1:0]       wr_cnt;
    logic [NUM_LOG-1:0]        wr_cw;
    logic                      wr_gctl, wr_imask, rd_stat;
    logic                      priv_ok, glob_gate;
    priv_filter_e              filt;

    assign gctl_q = regs_q.gctl;
    assign stat_q = regs_q.stat;

    // address decode
    always_comb begin
        wr_gctl  = reg_wr_i && (reg_addr_i == A_GCTL);
        wr_imask = reg_wr_i && (reg_addr_i == A_IMASK);
        rd_stat  = reg_rd_i && (reg_addr_i == A_STAT);
        for (int n = 0; n < NUM_PHYS; n++) begin
            wr_cnt[n] = reg_wr_i && (reg_addr_i == A_CNT + ADDR_W'(n));
        end
        for (int k = 0; k < NUM_LOG; k++) begin
            wr_cw[k] = reg_wr_i && (reg_addr_i == A_CW + ADDR_W'(k));
        end
    end

    // global count gate: enable, freeze and privilege filter
    always_comb begin
        filt      = priv_filter_e'(regs_q.gctl[GC_MODE_HI:GC_MODE_LO]);
        priv_ok   = (filt == PRIV_ANY) || (priv_i == filt);
        glob_gate = regs_q.gctl[GC_ENABLE] && !regs_q.gctl[GC_FREEZE] && priv_ok;
    end

    genvar gk;
    generate
        for (gk = 0; gk < NUM_LOG; gk++) begin : g_cond
            pmon_evt_cond #(
                .NUM_EV (NUM_EV),
                .SEL_W  (SEL_W)
            ) u_cond (
                .clk    (clk),
                .rst_n  (rst_n),
                .ev_i   (ev_i),
                .sel_i  (regs_q.cw[gk][CW_SEL_LO +: SEL_W]),
                .inv_i  (regs_q.cw[gk][CW_INV]),
                .cyc_i  (regs_q.cw[gk][CW_CYC]),
                .gate_i (glob_gate && regs_q.cw[gk][CW_EN]),
                .inc_o  (inc_vec[gk])
            );
        end
    endgenerate

    genvar gn;
    generate
        for (gn = 0; gn < NUM_PHYS; gn++) begin : g_phys
            logic [REG_W-1:0] val;
            pmon_phys_ctr #(
                .W (REG_W)
            ) u_ctr (
                .clk      (clk),
                .rst_n    (rst_n),
                .split_i  (regs_q.gctl[GC_SPLIT_TOP - gn]),
                .stop_i   (regs_q.gctl[GC_STOPMAX]),
                .wr_i     (wr_cnt[gn]),
                .wdata_i  (reg_wdata_i),
                .inc_lo_i (inc_vec[gn]),
                .inc_hi_i (inc_vec[gn + NUM_PHYS]),
                .val_o    (val),
                .hit_lo_o (hit_vec[gn]),
                .hit_hi_o (hit_vec[gn + NUM_PHYS])
            );
            assign cnt_flat[gn*REG_W +: REG_W] = val;
        end
    endgenerate

    // next register state
    always_comb begin
        regs_d = regs_q;
        if (wr_gctl)  regs_d.gctl  = reg_wdata_i & GCTL_MASK;
        if (wr_imask) regs_d.imask = reg_wdata_i & IMASK_MASK;
        for (int k = 0; k < NUM_LOG; k++) begin
            if (wr_cw[k]) regs_d.cw[k] = reg_wdata_i & CW_MASK;
        end
        regs_d.stat = (rd_stat ? '0 : regs_q.stat) | hit_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    // read mux and interrupt
    always_comb begin
        reg_rdata_o = '0;
        for (int k = 0; k < NUM_LOG; k++) begin
            mask_vec[k] = regs_q.imask[ST_TOP - k];
        end
        if (reg_addr_i == A_GCTL)  reg_rdata_o = regs_q.gctl;
        if (reg_addr_i == A_IMASK) reg_rdata_o = regs_q.imask;
        if (reg_addr_i == A_STAT) begin
            for (int k = 0; k < NUM_LOG; k++) begin
                reg_rdata_o[ST_TOP - k] = regs_q.stat[k];
            end
        end
        for (int n = 0; n < NUM_PHYS; n++) begin
            if (reg_addr_i == A_CNT + ADDR_W'(n)) reg_rdata_o = cnt_flat[n*REG_W +: REG_W];
        end
        for (int k = 0; k < NUM_LOG; k++) begin
            if (reg_addr_i == A_CW + ADDR_W'(k)) reg_rdata_o = regs_q.cw[k];
        end
        irq_o = |(regs_q.stat & mask_vec);
    end

endmodule

// File: rtl/pmon_core_chk.sv
module pmon_core_chk
    import pmon_pkg::*;
#(
    parameter int NUM_PHYS = 4,
    parameter int NUM_LOG  = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      reg_wr_i,
    input logic                      reg_rd_i,
    input logic [4:0]                reg_addr_i,
    input logic [31:0]               reg_wdata_i,
    input logic                      irq_o,
    input logic [31:0]               gctl_q,
    input logic [NUM_LOG-1:0]        stat_q,
    input logic [NUM_PHYS*32-1:0]    cnt_flat
);

    assert_gctl_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i == A_GCTL) |=> (gctl_q == ($past(reg_wdata_i) & GCTL_MASK)));

    assert_frozen_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (gctl_q[GC_FREEZE] && !reg_wr_i) |=> $stable(cnt_flat));

    assert_disabled_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!gctl_q[GC_ENABLE] && !reg_wr_i) |=> $stable(cnt_flat));

    assert_stop_at_max_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (gctl_q[GC_STOPMAX] && !gctl_q[GC_SPLIT_TOP] && (&cnt_flat[31:0])
         && !(reg_wr_i && reg_addr_i == A_CNT)) |=> (&cnt_flat[31:0]));

    assert_status_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd_i && reg_addr_i == A_STAT) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

    assert_irq_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i == A_IMASK && reg_wdata_i[31:24] == 8'h00) |=> !irq_o);

endmodule

bind pmon_core pmon_core_chk #(
    .NUM_PHYS (NUM_PHYS),
    .NUM_LOG  (NUM_LOG)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_i    (reg_wr_i),
    .reg_rd_i    (reg_rd_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .irq_o       (irq_o),
    .gctl_q      (gctl_q),
    .stat_q      (stat_q),
    .cnt_flat    (cnt_flat)
);

// File: tb/pmon_core_bench.sv
module pmon_core_bench;

    localparam int NUM_EV = 64;
    localparam logic [31:0] G_RUN  = 32'h800C_0000;
    localparam logic [31:0] CW_ON0 = 32'h00C0_0000;  // sel 0, cycles, enable
    localparam logic [31:0] CW_ON1 = 32'h04C0_0000;  // sel 1, cycles, enable

    typedef struct packed {
        logic [5:0] sel;
        logic       inv;
        logic       cyc;
        logic [7:0] pat;
        logic [7:0] exp;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{6'd5,  1'b0, 1'b1, 8'hF0, 8'd4},
        '{6'd63, 1'b1, 1'b1, 8'hC0, 8'd6},
        '{6'd0,  1'b0, 1'b0, 8'hAA, 8'd4},
        '{6'd17, 1'b0, 1'b0, 8'hFF, 8'd1},
        '{6'd40, 1'b1, 1'b0, 8'h00, 8'd1},
        '{6'd5,  1'b1, 1'b0, 8'h55, 8'd4},
        '{6'd9,  1'b0, 1'b1, 8'h00, 8'd0},
        '{6'd33, 1'b0, 1'b0, 8'h3C, 8'd1},
        '{6'd2,  1'b1, 1'b1, 8'h81, 8'd6}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NUM_EV-1:0] ev = '0;
    logic [1:0]        priv = 2'd0;
    logic              wr = 1'b0;
    logic              rd = 1'b0;
    logic [4:0]        addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic              irq;
    int                tests = 0;
    int                fails = 0;
    logic [31:0]       v;

    always #2 clk = ~clk;

    pmon_core u_pmon_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev_i        (ev),
        .priv_i      (priv),
        .reg_wr_i    (wr),
        .reg_rd_i    (rd),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wreg(input logic [4:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rreg(input logic [4:0] a, output logic [31:0] d);
        addr = a; rd = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic drive_ev(input int s, input logic val);
        ev = {NUM_EV{~val}};
        ev[s] = val;
    endtask

    task automatic window(input logic [31:0] g, input int n, input logic [NUM_EV-1:0] evv);
        ev = '0;
        wreg(5'd0, g);
        ev = evv;
        repeat (n) @(negedge clk);
        ev = '0;
        wreg(5'd0, 32'h0);
    endtask

    task automatic clear_cws();
        for (int k = 0; k < 8; k++) wreg(5'd16 + 5'(k), 32'h0);
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rreg(5'd0, v);  check("R1 gctl", v, 32'h0);
        rreg(5'd1, v);  check("R1 status", v, 32'h0);
        rreg(5'd2, v);  check("R1 mask", v, 32'h0);
        rreg(5'd11, v); check("R1 cnt3", v, 32'h0);
        rreg(5'd23, v); check("R1 cw7", v, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // R2 implemented bits
        wreg(5'd0, 32'hFFFF_FFFF);  rreg(5'd0, v);  check("R2 gctl", v, 32'hC1FC_0000);
        wreg(5'd21, 32'hFFFF_FFFF); rreg(5'd21, v); check("R2 cw5", v, 32'hFFC0_0000);
        wreg(5'd2, 32'hFFFF_FFFF);  rreg(5'd2, v);  check("R2 mask", v, 32'hFF00_0000);
        wreg(5'd0, 32'h0); wreg(5'd21, 32'h0); wreg(5'd2, 32'h0);

        // R3 / R4 vector table on logical counter 0
        for (int i = 0; i < 9; i++) begin
            drive_ev(int'(VECS[i].sel), VECS[i].inv);
            wreg(5'd8, 32'h0);
            wreg(5'd16, {VECS[i].sel, 1'b0, VECS[i].inv, VECS[i].cyc, 1'b1, 22'd0});
            wreg(5'd0, G_RUN);
            for (int j = 0; j < 8; j++) begin
                drive_ev(int'(VECS[i].sel), VECS[i].pat[j]);
                @(negedge clk);
            end
            drive_ev(int'(VECS[i].sel), VECS[i].inv);
            wreg(5'd0, 32'h0);
            rreg(5'd8, v);
            check(VECS[i].cyc ? "R3 cycle count" : "R4 edge count", v, {24'd0, VECS[i].exp});
        end

        // R7 gating
        clear_cws();
        wreg(5'd8, 32'h0);
        wreg(5'd16, CW_ON0);
        window(32'h801C_0000, 5, 64'd1); rreg(5'd8, v); check("R7 freeze", v, 32'd0);
        window(32'h000C_0000, 5, 64'd1); rreg(5'd8, v); check("R7 global off", v, 32'd0);
        wreg(5'd16, 32'h0080_0000);
        window(G_RUN, 5, 64'd1);         rreg(5'd8, v); check("R7 counter off", v, 32'd0);
        wreg(5'd16, CW_ON0);
        window(G_RUN, 5, 64'd1);         rreg(5'd8, v); check("R7 running", v, 32'd5);

        // R8 privilege filter
        wreg(5'd8, 32'h0);
        priv = 2'd0; window(32'h8008_0000, 4, 64'd1); rreg(5'd8, v); check("R8 user blocks sup", v, 32'd0);
        priv = 2'd2; window(32'h8008_0000, 3, 64'd1); rreg(5'd8, v); check("R8 user match", v, 32'd3);
        priv = 2'd2; window(32'h8004_0000, 4, 64'd1); rreg(5'd8, v); check("R8 hyp blocks user", v, 32'd3);
        priv = 2'd1; window(32'h8004_0000, 2, 64'd1); rreg(5'd8, v); check("R8 hyp match", v, 32'd5);
        priv = 2'd0; window(32'h8000_0000, 1, 64'd1); rreg(5'd8, v); check("R8 sup match", v, 32'd6);

        // R5 full-width carry, and only control word n drives it
        clear_cws();
        wreg(5'd9, 32'h0000_FFFE);
        wreg(5'd17, CW_ON0);
        window(G_RUN, 3, 64'd1); rreg(5'd9, v); check("R5 carry", v, 32'h0001_0001);
        wreg(5'd17, 32'h0);
        wreg(5'd21, CW_ON1);
        window(G_RUN, 4, 64'd2); rreg(5'd9, v); check("R5 upper word unused", v, 32'h0001_0001);

        // R12 write beats increment
        clear_cws();
        wreg(5'd17, CW_ON0);
        ev = 64'd1;
        wreg(5'd0, G_RUN);
        wreg(5'd9, 32'h0000_0100);
        ev = '0;
        wreg(5'd0, 32'h0);
        rreg(5'd9, v); check("R12 write priority", v, 32'h0000_0100);

        // R6 split halves, R10 flags
        clear_cws();
        rreg(5'd1, v);
        wreg(5'd10, 32'h1234_FFFE);
        wreg(5'd18, CW_ON0);
        wreg(5'd22, CW_ON1);
        window(32'h804C_0000, 3, 64'd1); rreg(5'd10, v); check("R6 low wraps alone", v, 32'h1234_0001);
        rreg(5'd1, v); check("R10 flag k2", v, 32'h2000_0000);
        rreg(5'd1, v); check("R10 clear on read", v, 32'h0);
        window(32'h804C_0000, 2, 64'd2); rreg(5'd10, v); check("R6 high half", v, 32'h1236_0001);
        wreg(5'd10, 32'hFFFE_0000);
        window(32'h804C_0000, 1, 64'd2); rreg(5'd10, v); check("R6 high max", v, 32'hFFFF_0000);
        rreg(5'd1, v); check("R10 flag k6", v, 32'h0200_0000);

        // R9 stop-at-max and wrap, R11 interrupt
        clear_cws();
        wreg(5'd11, 32'hFFFF_FFFD);
        wreg(5'd19, CW_ON0);
        window(32'hC00C_0000, 5, 64'd1); rreg(5'd11, v); check("R9 hold at max", v, 32'hFFFF_FFFF);
        check("R11 unmasked", {31'b0, irq}, 32'h0);
        wreg(5'd2, 32'h0100_0000);
        check("R11 other bit masked", {31'b0, irq}, 32'h0);
        wreg(5'd2, 32'h1000_0000);
        check("R11 raised", {31'b0, irq}, 32'h1);
        rreg(5'd1, v); check("R10 flag k3", v, 32'h1000_0000);
        check("R11 dropped after read", {31'b0, irq}, 32'h0);
        wreg(5'd11, 32'hFFFF_FFFE);
        window(G_RUN, 3, 64'd1); rreg(5'd11, v); check("R9 wrap", v, 32'h0000_0001);
        check("R11 raised again", {31'b0, irq}, 32'h1);
        rreg(5'd1, v); check("R10 flag on wrap", v, 32'h1000_0000);
        wreg(5'd19, 32'h0);
        wreg(5'd8, 32'h0000_FFFE);
        wreg(5'd16, CW_ON0);
        window(32'hC10C_0000, 4, 64'd1); rreg(5'd8, v); check("R9 split hold", v, 32'h0000_FFFF);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule